// File: doc/BRIEF.md
# Maintenance Request Range Splitter

This block sits between a requester and a downstream cache maintenance engine. It takes one request: an operation (invalidate, clean or flush) and a half-open byte range `[start, end)`. It turns that request into an ordered series of commands that the engine accepts over a valid/ready handshake. There are two kinds of command. A single-line clean-and-invalidate names one line. A range command names an inclusive first line address and an inclusive last line address.

Lines are 32 bytes. For an invalidate, lines that the range covers only in part are not simply dropped. A line partly covered at the start or at the end gets a single-line clean-and-invalidate, so the bytes of that line outside the range survive. Only the lines that lie fully inside the range are invalidated as ranges. Clean and flush requests widen the range outward to whole lines. Every range command is capped at 1024 bytes and never crosses a 4 KiB page boundary. A write-through mode input makes clean requests complete without issuing any command.

Top module: `maint_range_splitter`

## Requirements
- R1: `req_ready` is high only while the block is idle, and a request is taken only when `req_valid` and `req_ready` are both high. `done` is high for exactly one cycle: the cycle after the edge that accepts the final command, or the cycle after acceptance when no command is due. `req_ready` returns high in the following cycle.
- R2: Every command address is a multiple of 32. For a range command, `cmd_last` equals the chunk's exclusive end minus 32. For a single-line command (`cmd_kind` 0), `cmd_first` equals `cmd_last`.
- R3: A range command covers at most 1024 bytes: `cmd_last - cmd_first + 32 <= 1024`.
- R4: A range command never crosses a 4 KiB page: `cmd_first` and `cmd_last` agree in bits 31 down to 12.
- R5: For an invalidate (`req_op` 0) whose start is not a multiple of 32, the first command is a single-line clean-and-invalidate (`cmd_kind` 0) of the line containing the start. Range coverage then begins at the next line boundary.
- R6: For an invalidate, if the advanced start is still below the end and the end is not a multiple of 32, a single-line clean-and-invalidate of the line containing the end follows. The range is then cut down to that line's base. If the advanced start is not below the end, no further command is issued.
- R7: For a clean (`req_op` 1) or flush (`req_op` 2, and also 3), the start is rounded down and the end rounded up to a multiple of 32 before splitting.
- R8: For a flush, each chunk is issued as a range clean (`cmd_kind` 1) immediately followed by a range invalidate (`cmd_kind` 2) with the same first and last addresses. Range commands for an invalidate use `cmd_kind` 2, and those for a clean use `cmd_kind` 1.
- R9: With `wt_override` high at acceptance, a clean request issues no command and completes as in R1. Invalidate and flush requests are unaffected by this input.
- R10: Range chunks come in ascending order, and each chunk starts 32 bytes above the previous chunk's `cmd_last`.
- R11: A request whose aligned start equals its aligned end issues no command and raises `done` in the cycle after acceptance.
- R12: `cmd_kind`, `cmd_first` and `cmd_last` hold steady while `cmd_valid` is high and `cmd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 or 3 flush |
| req_start | input | ADDR_W | First byte address (inclusive) |
| req_end | input | ADDR_W | End byte address (exclusive) |
| wt_override | input | 1 | Write-through mode: clean requests do nothing |
| cmd_valid | output | 1 | Command present for the engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_kind | output | 2 | 0 line clean+invalidate, 1 range clean, 2 range invalidate |
| cmd_first | output | ADDR_W | First line address (inclusive) |
| cmd_last | output | ADDR_W | Last line address (inclusive) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first command appears in the cycle after a request is accepted. Each later command is presented in the cycle after the edge that takes the previous one, and `done` rises in the cycle after the edge that takes the final command. An empty or suppressed request raises `done` one cycle after acceptance.

The bench drives and samples on the falling edge. It throttles `cmd_ready` in a fixed pattern and records a handshake only when valid and ready are both high at that sample. It flags any `done` that is not preceded by a handshake or an acceptance on the edge just before it. A table of requests is checked for the count of commands and for the first and last command of each request. Every recorded range command is also checked against the size and page limits.

// File: rtl/maint_split_pkg.sv
`timescale 1ns/1ps
package maint_split_pkg;

    typedef enum logic [1:0] {
        OP_INV   = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2
    } maint_op_e;

    typedef enum logic [1:0] {
        CMD_LINE_CINV   = 2'd0,
        CMD_RANGE_CLEAN = 2'd1,
        CMD_RANGE_INV   = 2'd2
    } cmd_kind_e;

    // Outstanding work of the current request.
    typedef struct packed {
        logic head;      // single-line command for the start line pending
        logic tail;      // single-line command for the end line pending
        logic inv_half;  // flush: clean half of this chunk already sent
    } pend_t;

    function automatic maint_op_e decode_op(input logic [1:0] raw);
        case (raw)
            2'd0:    return OP_INV;
            2'd1:    return OP_CLEAN;
            default: return OP_FLUSH;
        endcase
    endfunction

endpackage

// File: rtl/maint_req_align.sv
`timescale 1ns/1ps
module maint_req_align
    import maint_split_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LINE_LG = 5
) (
    input  maint_op_e          op,
    input  logic               wt,
    input  logic [ADDR_W-1:0]  start_a,
    input  logic [ADDR_W-1:0]  end_a,
    output logic               head_pend,
    output logic               tail_pend,
    output logic [ADDR_W-1:0]  head_line,
    output logic [ADDR_W-1:0]  tail_line,
    output logic [ADDR_W:0]    span_lo,
    output logic [ADDR_W:0]    span_hi
);
    localparam logic [ADDR_W:0] OFS = {{(ADDR_W + 1 - LINE_LG){1'b0}}, {LINE_LG{1'b1}}};

    logic [ADDR_W:0] s_ext, e_ext, s_dn, s_up, e_dn, e_up;
    logic            s_unal, e_unal;

    assign s_ext  = {1'b0, start_a};
    assign e_ext  = {1'b0, end_a};
    assign s_dn   = s_ext & ~OFS;
    assign e_dn   = e_ext & ~OFS;
    assign s_up   = (s_ext + OFS) & ~OFS;
    assign e_up   = (e_ext + OFS) & ~OFS;
    assign s_unal = |start_a[LINE_LG-1:0];
    assign e_unal = |end_a[LINE_LG-1:0];

    assign head_line = s_dn[ADDR_W-1:0];
    assign tail_line = e_dn[ADDR_W-1:0];

    always_comb begin
        head_pend = 1'b0;
        tail_pend = 1'b0;
        span_lo   = s_dn;
        span_hi   = e_up;
        case (op)
            OP_INV: begin
                head_pend = s_unal;
                tail_pend = (s_up < e_ext) && e_unal;
                span_lo   = s_up;
                span_hi   = tail_pend ? e_dn : e_ext;
            end
            OP_CLEAN: begin
                span_hi = wt ? s_dn : e_up;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/maint_chunk_calc.sv
`timescale 1ns/1ps
module maint_chunk_calc #(
    parameter int ADDR_W    = 32,
    parameter int MAX_BYTES = 1024,
    parameter int PAGE_LG   = 12
) (
    input  logic [ADDR_W:0] lo,
    input  logic [ADDR_W:0] hi,
    output logic [ADDR_W:0] nxt
);
    localparam logic [ADDR_W:0] PMASK = {{(ADDR_W + 1 - PAGE_LG){1'b0}}, {PAGE_LG{1'b1}}};
    localparam logic [ADDR_W:0] MAXV  = (ADDR_W + 1)'(MAX_BYTES);

    logic [ADDR_W:0] size_cap, page_cap, first_min;

    assign size_cap  = lo + MAXV;
    assign page_cap  = (lo | PMASK) + 1'b1;
    assign first_min = (size_cap < page_cap) ? size_cap : page_cap;
    assign nxt       = (hi < first_min) ? hi : first_min;
endmodule

// File: rtl/maint_range_splitter.sv
`timescale 1ns/1ps
module maint_range_splitter
    import maint_split_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int MAX_BYTES  = 1024,
    parameter int PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    input  logic              wt_override,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_first,
    output logic [ADDR_W-1:0] cmd_last,
    output logic              done
);
    localparam int LINE_LG = $clog2(LINE_BYTES);
    localparam int PAGE_LG = $clog2(PAGE_BYTES);
    localparam logic [ADDR_W:0]   LINE_X = (ADDR_W + 1)'(LINE_BYTES);
    localparam logic [ADDR_W-1:0] LINE_A = ADDR_W'(LINE_BYTES);
    localparam logic [ADDR_W-1:0] MAX_A  = ADDR_W'(MAX_BYTES);

    maint_op_e         op_in, op_q;
    logic              busy, work, hs;
    pend_t             pend_q;
    logic [ADDR_W-1:0] head_q, tail_q;
    logic [ADDR_W:0]   cur_q, lim_q, nxt, last_x;
    logic              a_head, a_tail;
    logic [ADDR_W-1:0] a_hline, a_tline;
    logic [ADDR_W:0]   a_lo, a_hi;
    cmd_kind_e         kind;

    assign op_in = decode_op(req_op);

    maint_req_align #(.ADDR_W(ADDR_W), .LINE_LG(LINE_LG)) u_align (
        .op(op_in), .wt(wt_override), .start_a(req_start), .end_a(req_end),
        .head_pend(a_head), .tail_pend(a_tail),
        .head_line(a_hline), .tail_line(a_tline),
        .span_lo(a_lo), .span_hi(a_hi)
    );

    maint_chunk_calc #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES), .PAGE_LG(PAGE_LG)) u_chunk (
        .lo(cur_q), .hi(lim_q), .nxt(nxt)
    );

    assign work      = pend_q.head || pend_q.tail || (cur_q < lim_q);
    assign cmd_valid = busy && work;
    assign done      = busy && !work;
    assign req_ready = !busy;
    assign hs        = cmd_valid && cmd_ready;
    assign last_x    = nxt - LINE_X;

    always_comb begin
        if (pend_q.head) begin
            kind      = CMD_LINE_CINV;
            cmd_first = head_q;
            cmd_last  = head_q;
        end else if (pend_q.tail) begin
            kind      = CMD_LINE_CINV;
            cmd_first = tail_q;
            cmd_last  = tail_q;
        end else begin
            kind      = (op_q == OP_CLEAN || (op_q == OP_FLUSH && !pend_q.inv_half))
                        ? CMD_RANGE_CLEAN : CMD_RANGE_INV;
            cmd_first = cur_q[ADDR_W-1:0];
            cmd_last  = last_x[ADDR_W-1:0];
        end
    end
    assign cmd_kind = kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            op_q   <= OP_INV;
            pend_q <= '0;
            head_q <= '0;
            tail_q <= '0;
            cur_q  <= '0;
            lim_q  <= '0;
        end else if (!busy) begin
            if (req_valid) begin
                busy            <= 1'b1;
                op_q            <= op_in;
                pend_q.head     <= a_head;
                pend_q.tail     <= a_tail;
                pend_q.inv_half <= 1'b0;
                head_q          <= a_hline;
                tail_q          <= a_tline;
                cur_q           <= a_lo;
                lim_q           <= a_hi;
            end
        end else if (!work) begin
            busy <= 1'b0;
        end else if (cmd_ready) begin
            if (pend_q.head) begin
                pend_q.head <= 1'b0;
            end else if (pend_q.tail) begin
                pend_q.tail <= 1'b0;
            end else if (op_q == OP_FLUSH && !pend_q.inv_half) begin
                pend_q.inv_half <= 1'b1;
            end else begin
                pend_q.inv_half <= 1'b0;
                cur_q           <= nxt;
            end
        end
    end

    // R1: after taking a request the block stops offering ready
    assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    // R1: done never coincides with a command offer
    assert_done_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
        done |-> !cmd_valid);
    // R2: every address is line aligned
    assert_line_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_first[LINE_LG-1:0] == '0 && cmd_last[LINE_LG-1:0] == '0));
    // R3: range size cap
    assert_chunk_size_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind != CMD_LINE_CINV) |->
        (cmd_last >= cmd_first && (cmd_last - cmd_first) < MAX_A));
    // R4: range stays in one page
    assert_same_page_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind != CMD_LINE_CINV) |->
        (cmd_first[ADDR_W-1:PAGE_LG] == cmd_last[ADDR_W-1:PAGE_LG]));
    // R8: flush clean half is followed by an invalidate of the same span
    assert_flush_pair_R8: assert property (@(posedge clk) disable iff (rst)
        (hs && cmd_kind == CMD_RANGE_CLEAN && op_q == OP_FLUSH) |=>
        (cmd_valid && cmd_kind == CMD_RANGE_INV &&
         cmd_first == $past(cmd_first) && cmd_last == $past(cmd_last)));
    // R9: a clean in write-through mode completes with nothing issued
    assert_wt_clean_silent_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_op == 2'd1 && wt_override) |=> (done && !cmd_valid));
    // R10: chunks are contiguous and ascending
    assert_contiguous_R10: assert property (@(posedge clk) disable iff (rst)
        (hs && (cmd_kind == CMD_RANGE_INV || (cmd_kind == CMD_RANGE_CLEAN && op_q == OP_CLEAN))) |=>
        (!cmd_valid || cmd_first == $past(cmd_last) + LINE_A));
    // R12: command held while stalled
    assert_hold_stall_R12: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=>
        (cmd_valid && $stable(cmd_kind) && $stable(cmd_first) && $stable(cmd_last)));
endmodule

// File: tb/test_maint_range_splitter.sv
`timescale 1ns/1ps
module test_maint_range_splitter;

    typedef struct packed {
        logic [1:0]  op;
        logic        wt;
        logic [31:0] s;
        logic [31:0] e;
        logic [7:0]  n;
        logic [1:0]  fk;
        logic [31:0] fa;
        logic [31:0] fb;
        logic [1:0]  lk;
        logic [31:0] la;
        logic [31:0] lb;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 32'h1000, 32'h1080, 8'd1, 2'd2, 32'h1000, 32'h1060, 2'd2, 32'h1000, 32'h1060}, // R2 aligned inv
        '{2'd0, 1'b0, 32'h1010, 32'h1090, 8'd3, 2'd0, 32'h1000, 32'h1000, 2'd2, 32'h1020, 32'h1060}, // R5 R6
        '{2'd0, 1'b0, 32'h1004, 32'h1008, 8'd1, 2'd0, 32'h1000, 32'h1000, 2'd0, 32'h1000, 32'h1000}, // R6 inside one line
        '{2'd1, 1'b0, 32'h0FF0, 32'h1010, 8'd2, 2'd1, 32'h0FE0, 32'h0FE0, 2'd1, 32'h1000, 32'h1000}, // R4 R7
        '{2'd1, 1'b0, 32'h2000, 32'h2900, 8'd3, 2'd1, 32'h2000, 32'h23E0, 2'd1, 32'h2800, 32'h28E0}, // R3 R10
        '{2'd2, 1'b0, 32'h3F01, 32'h4005, 8'd4, 2'd1, 32'h3F00, 32'h3FE0, 2'd2, 32'h4000, 32'h4000}, // R8 R4
        '{2'd1, 1'b1, 32'h5000, 32'h5100, 8'd0, 2'd0, 32'h0,    32'h0,    2'd0, 32'h0,    32'h0   }, // R9
        '{2'd2, 1'b1, 32'h5000, 32'h5020, 8'd2, 2'd1, 32'h5000, 32'h5000, 2'd2, 32'h5000, 32'h5000}, // R9 flush kept
        '{2'd0, 1'b1, 32'h6000, 32'h6040, 8'd1, 2'd2, 32'h6000, 32'h6020, 2'd2, 32'h6000, 32'h6020}, // R9 inv kept
        '{2'd0, 1'b0, 32'h7000, 32'h7000, 8'd0, 2'd0, 32'h0,    32'h0,    2'd0, 32'h0,    32'h0   }, // R11
        '{2'd1, 1'b0, 32'h7010, 32'h7010, 8'd1, 2'd1, 32'h7000, 32'h7000, 2'd1, 32'h7000, 32'h7000}, // R7
        '{2'd0, 1'b0, 32'h8000, 32'h8C00, 8'd3, 2'd2, 32'h8000, 32'h83E0, 2'd2, 32'h8800, 32'h8BE0}, // R3 R10
        '{2'd0, 1'b0, 32'h9FF8, 32'hA410, 8'd3, 2'd0, 32'h9FE0, 32'h9FE0, 2'd2, 32'hA000, 32'hA3E0}  // R5 R6
    };

    function automatic string vec_req(input int i);
        case (i)
            0: return "R2";   1: return "R5";  2: return "R6";  3: return "R7";
            4: return "R3";   5: return "R8";  6: return "R9";  7: return "R9";
            8: return "R9";   9: return "R11"; 10: return "R7"; 11: return "R10";
            default: return "R6";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_start = '0;
    logic [31:0] req_end = '0;
    logic        wt_override = 1'b0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [1:0]  cmd_kind;
    logic [31:0] cmd_first, cmd_last;
    logic        done;

    always #2.5 clk = ~clk;

    maint_range_splitter i_maint_range_splitter (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_start(req_start), .req_end(req_end),
        .wt_override(wt_override), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_first(cmd_first), .cmd_last(cmd_last), .done(done)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int got_n  = 0;
    logic [1:0]  got_k [64];
    logic [31:0] got_a [64];
    logic [31:0] got_b [64];
    logic done_seen = 1'b0;
    logic prev_hs   = 1'b0;
    logic prev_acc  = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: drives cmd_ready, samples everything 1 ns after the falling edge.
    always begin
        @(negedge clk);
        cyc++;
        cmd_ready = (cyc % 3) != 2;
        #1;
        if (!rst) begin
            if (done) begin
                check(prev_hs || prev_acc, "R1", "done not right after last handshake/accept",
                      32'(done), 32'(0));
                check(!cmd_valid, "R1", "done with cmd_valid", 32'(cmd_valid), 32'(0));
                done_seen = 1'b1;
            end
            if (cmd_valid && cmd_ready && got_n < 64) begin
                got_k[got_n] = cmd_kind;
                got_a[got_n] = cmd_first;
                got_b[got_n] = cmd_last;
                got_n++;
                if (cmd_kind != 2'd0) begin
                    check((cmd_last - cmd_first + 32'd32) <= 32'd1024, "R3", "chunk size",
                          cmd_last - cmd_first + 32'd32, 32'd1024);
                    check(cmd_first[31:12] == cmd_last[31:12], "R4", "page crossing",
                          cmd_last, cmd_first);
                end else begin
                    check(cmd_first == cmd_last, "R2", "line cmd first/last", cmd_last, cmd_first);
                end
            end
            prev_hs  = cmd_valid && cmd_ready;
            prev_acc = req_valid && req_ready;
        end else begin
            prev_hs  = 1'b0;
            prev_acc = 1'b0;
        end
    end

    task automatic issue(input logic [1:0] op, input logic wt,
                         input logic [31:0] s, input logic [31:0] e);
        got_n     = 0;
        done_seen = 1'b0;
        @(negedge clk);
        req_valid   = 1'b1;
        req_op      = op;
        wt_override = wt;
        req_start   = s;
        req_end     = e;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int k;
        k = 0;
        while (!done_seen && k < 2000) begin
            @(negedge clk);
            #2;
            k++;
        end
        check(done_seen, req, "done never seen (watchdog)", 32'(k), 32'd2000);
        repeat (3) @(negedge clk);
        #2;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #2;
        // Reset state
        check(req_ready == 1'b1, "R1", "reset req_ready", 32'(req_ready), 32'd1);
        check(cmd_valid == 1'b0, "R1", "reset cmd_valid", 32'(cmd_valid), 32'd0);
        check(done == 1'b0, "R1", "reset done", 32'(done), 32'd0);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].wt, VECS[i].s, VECS[i].e);
            wait_done(vec_req(i));
            check(got_n == int'(VECS[i].n), vec_req(i), "command count",
                  32'(got_n), 32'(VECS[i].n));
            if (VECS[i].n != 0 && got_n == int'(VECS[i].n)) begin
                check(got_k[0] == VECS[i].fk && got_a[0] == VECS[i].fa && got_b[0] == VECS[i].fb,
                      vec_req(i), "first command", got_a[0], VECS[i].fa);
                check(got_k[got_n-1] == VECS[i].lk && got_a[got_n-1] == VECS[i].la &&
                      got_b[got_n-1] == VECS[i].lb,
                      vec_req(i), "last command", got_b[got_n-1], VECS[i].lb);
            end
        end

        // R8: flush pairs, every clean followed by invalidate of same span
        issue(2'd2, 1'b0, 32'hB000, 32'hB900);
        wait_done("R8");
        check(got_n == 6, "R8", "flush command count", 32'(got_n), 32'd6);
        for (int j = 0; j + 1 < got_n; j += 2) begin
            check(got_k[j] == 2'd1 && got_k[j+1] == 2'd2 && got_a[j] == got_a[j+1] &&
                  got_b[j] == got_b[j+1], "R8", "flush pair", got_a[j+1], got_a[j]);
        end
        // R10: contiguity across chunks
        for (int j = 2; j < got_n; j += 2) begin
            check(got_a[j] == got_b[j-1] + 32'd32, "R10", "chunk contiguity",
                  got_a[j], got_b[j-1] + 32'd32);
        end

        // R1: a request offered while busy is ignored
        issue(2'd0, 1'b0, 32'h8000, 32'h8C00);
        @(negedge clk);
        #1.5;
        check(req_ready == 1'b0, "R1", "req_ready while busy", 32'(req_ready), 32'd0);
        req_valid = 1'b1;
        req_op    = 2'd1;
        req_start = 32'hC000;
        req_end   = 32'hC020;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done("R1");
        check(got_n == 3 && got_a[0] == 32'h8000 && got_b[2] == 32'h8BE0, "R1",
              "busy request leaked", 32'(got_n), 32'd3);
        check(req_ready == 1'b1 && cmd_valid == 1'b0, "R1", "idle after request",
              32'(req_ready), 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #900000;
        fails++;
        checks++;
        $display("FAIL R1 global watchdog: actual %0d expected %0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule